// File: doc/BRIEF.md
# Multicast Port Flush Sequencer

This block removes a chosen set of switch ports from the multicast entries of an address lookup table. A single start pulse supplies a flush port mask, a 12-bit VLAN identifier and a flag that disables the VLAN filter. The sequencer then visits every table index once, in ascending order. For each index it reads the entry in one cycle and, in the following cycle, decides what to write back.

Only address-class entries are rewritten. An entry is changed when it is multicast, is not marked supervisory, does not carry the broadcast address, and its port mask shares at least one bit with the flush mask. The change clears the flush bits from the entry's port mask. If the mask that remains is empty, the entry is released by setting its type to free. Address-class entries that pass the VLAN filter but need no change are still written back with identical contents. Other entry types are never written.

The block drives the table's synchronous read port and write port directly. It holds busy for the whole scan and signals completion with a one-cycle done pulse.

Top module: `mpf_flush_seq`

## Requirements
- R1: While reset is active and directly after it, busy_o and done_o are 0 and neither tbl_rd_en_o nor tbl_wr_en_o is asserted.
- R2: A start_i pulse seen while idle begins a scan using the mask, VID and all-VLAN flag sampled on that edge. busy_o stays 1 for exactly 2*DEPTH cycles. A start_i pulse during a scan is ignored, so the values latched earlier stay in force.
- R3: Each index 0..DEPTH-1 is visited in ascending order. A read cycle is followed by one decision cycle, and any write in that cycle goes to the same address that was just read. The table has one cycle of read latency.
- R4: An entry is written only when its type field (bits 61:60) is 1 (address) or 3 (VLAN plus address). Types 0 (free) and 2 (VLAN) are never written.
- R5: With all_vlan_i at 0, an entry is written only when its VLAN field (bits 59:48) equals the requested VID. With all_vlan_i at 1, the VID is not compared.
- R6: An address-class entry whose multicast bit (bit 40) is 0 is written back unchanged.
- R7: An entry whose supervisory bit (bit 65) is 1 is written back unchanged.
- R8: An entry whose 48-bit address (bits 47:0) is all ones is written back unchanged.
- R9: A multicast entry whose port mask (bits 66 upward, NUM_PORTS wide) shares no bit with the flush mask is written back unchanged.
- R10: Otherwise, the flush bits are cleared from the port mask. When the remaining mask is non-zero, it is stored and every other bit is kept.
- R11: When the remaining mask is zero, the type field is written as 0 (free). All other bits, including the old port mask, are kept.
- R12: done_o is a single-cycle pulse. It comes in the cycle after the last index's decision cycle, and busy_o is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; ignored while busy |
| flush_mask_i | input | NUM_PORTS | Ports to remove from multicast entries |
| vid_i | input | 12 | VLAN identifier to match |
| all_vlan_i | input | 1 | 1 = ignore the VLAN field |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tbl_addr_o | output | AW | Table index for read and write |
| tbl_rd_en_o | output | 1 | Read request; data returns next cycle |
| tbl_rd_data_i | input | 66+NUM_PORTS | Entry read from the table |
| tbl_wr_en_o | output | 1 | Write strobe |
| tbl_wr_data_o | output | 66+NUM_PORTS | Entry written to the table |

## Verification
Some properties are checked on every cycle. Every write must follow a read of the same address. It must hit an address-class entry that passes the VLAN filter. Supervisory, broadcast and unicast entries must come back bit-identical. A rewritten port mask must be a subset of the old mask. Freeing must happen only when no port remains. done must be a lone pulse while idle.

Other behaviour is shown only by the bench's sweeps over flush masks, VLAN modes and table contents. These cover the exact final table, the number of writes to each index, the length of the scan, and the rejection of a second start in mid-scan.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  // Field positions inside one table entry; neighbours decode these.
  localparam int TYPE_LSB   = 60;
  localparam int VLAN_LSB   = 48;
  localparam int VLAN_W     = 12;
  localparam int ADDR_W     = 48;
  localparam int MCAST_BIT  = 40;
  localparam int SUPER_BIT  = 65;
  localparam int PMASK_LSB  = 66;

  typedef enum logic [1:0] {
    ENT_FREE      = 2'd0,
    ENT_ADDR      = 2'd1,
    ENT_VLAN      = 2'd2,
    ENT_VLAN_ADDR = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_READ = 2'd1,
    SC_DECIDE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/mpf_rst_sync.sv
module mpf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/mpf_scan_ctrl.sv
module mpf_scan_ctrl
  import mpf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] idx,
  output logic          rd_slot,
  output logic          decide_slot,
  output logic          busy,
  output logic          done,
  output logic          launch
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  scan_state_e   state_q, state_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic          idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    done_d  = 1'b0;
    launch  = 1'b0;
    unique case (state_q)
      SC_IDLE: begin
        if (start) begin
          state_d = SC_READ;
          idx_d   = '0;
          idx_en  = 1'b1;
          launch  = 1'b1;
        end
      end
      SC_READ: state_d = SC_DECIDE;
      SC_DECIDE: begin
        if (idx_q == LAST_IDX) begin
          state_d = SC_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = SC_READ;
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
        end
      end
      default: state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx         = idx_q;
  assign rd_slot     = (state_q == SC_READ);
  assign decide_slot = (state_q == SC_DECIDE);
  assign busy        = (state_q != SC_IDLE);
  assign done        = done_q;

  // R12: done is a lone pulse and arrives while idle
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == SC_IDLE));
  // R2: a start during a read slot does not disturb the scan
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_READ && start) |=> (state_q == SC_DECIDE && $stable(idx_q)));
  // R3: a decision slot always follows a read slot
  p_read_then_decide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SC_READ) |=> (state_q == SC_DECIDE));
endmodule

// File: rtl/mpf_entry_edit.sv
module mpf_entry_edit
  import mpf_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  localparam int EW = PMASK_LSB + NUM_PORTS
) (
  input  logic [EW-1:0]        entry_in,
  input  logic [NUM_PORTS-1:0] flush_mask,
  input  logic [VLAN_W-1:0]    vid,
  input  logic                 all_vlan,
  output logic                 write_back,
  output logic [EW-1:0]        entry_out
);
  ent_type_e            etype;
  logic                 is_addr_class;
  logic                 vlan_ok;
  logic                 is_mcast;
  logic                 is_super;
  logic                 is_bcast;
  logic [NUM_PORTS-1:0] pmask;
  logic [NUM_PORTS-1:0] remain;
  logic                 hit;
  logic                 modify;

  always_comb begin
    etype         = ent_type_e'(entry_in[TYPE_LSB +: 2]);
    is_addr_class = (etype == ENT_ADDR) || (etype == ENT_VLAN_ADDR);
    vlan_ok       = all_vlan || (entry_in[VLAN_LSB +: VLAN_W] == vid);
    is_mcast      = entry_in[MCAST_BIT];
    is_super      = entry_in[SUPER_BIT];
    is_bcast      = &entry_in[ADDR_W-1:0];
    pmask         = entry_in[PMASK_LSB +: NUM_PORTS];
    hit           = |(pmask & flush_mask);
    remain        = pmask & ~flush_mask;
    modify        = is_mcast && !is_super && !is_bcast && hit;
    write_back    = is_addr_class && vlan_ok;

    entry_out = entry_in;
    if (modify) begin
      if (remain == '0) begin
        entry_out[TYPE_LSB +: 2] = ENT_FREE;
      end else begin
        entry_out[PMASK_LSB +: NUM_PORTS] = remain;
      end
    end
  end
endmodule

// File: rtl/mpf_flush_seq.sv
module mpf_flush_seq
  import mpf_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DEPTH     = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW = PMASK_LSB + NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_PORTS-1:0] flush_mask_i,
  input  logic [VLAN_W-1:0]    vid_i,
  input  logic                 all_vlan_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [AW-1:0]        tbl_addr_o,
  output logic                 tbl_rd_en_o,
  input  logic [EW-1:0]        tbl_rd_data_i,
  output logic                 tbl_wr_en_o,
  output logic [EW-1:0]        tbl_wr_data_o
);
  logic                 rst_n_s;
  logic                 rd_slot;
  logic                 decide_slot;
  logic                 launch;
  logic                 write_back;
  logic [EW-1:0]        edited;
  logic [NUM_PORTS-1:0] fmask_q;
  logic [VLAN_W-1:0]    vid_q;
  logic                 allv_q;

  mpf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mpf_scan_ctrl #(.DEPTH(DEPTH)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start_i),
    .idx         (tbl_addr_o),
    .rd_slot     (rd_slot),
    .decide_slot (decide_slot),
    .busy        (busy_o),
    .done        (done_o),
    .launch      (launch)
  );

  // request parameters captured only when a scan is launched
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      fmask_q <= '0;
      vid_q   <= '0;
      allv_q  <= 1'b0;
    end else if (launch) begin
      fmask_q <= flush_mask_i;
      vid_q   <= vid_i;
      allv_q  <= all_vlan_i;
    end
  end

  mpf_entry_edit #(.NUM_PORTS(NUM_PORTS)) u_edit (
    .entry_in   (tbl_rd_data_i),
    .flush_mask (fmask_q),
    .vid        (vid_q),
    .all_vlan   (allv_q),
    .write_back (write_back),
    .entry_out  (edited)
  );

  assign tbl_rd_en_o   = rd_slot;
  assign tbl_wr_en_o   = decide_slot && write_back;
  assign tbl_wr_data_o = edited;

  // R1: idle and quiet straight out of reset
  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!busy_o && !done_o && !tbl_rd_en_o && !tbl_wr_en_o));
  // R3: a write targets the address read one cycle earlier
  p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    tbl_wr_en_o |-> ($past(tbl_rd_en_o) && tbl_addr_o == $past(tbl_addr_o)));
  // R4: only address-class entries are written
  p_wr_type_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    tbl_wr_en_o |-> (tbl_rd_data_i[TYPE_LSB +: 2] == ENT_ADDR ||
                     tbl_rd_data_i[TYPE_LSB +: 2] == ENT_VLAN_ADDR));
  // R5: VLAN filter holds when the bypass flag is clear
  p_vlan_filter_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tbl_wr_en_o && !allv_q) |-> (tbl_rd_data_i[VLAN_LSB +: VLAN_W] == vid_q));
  // R6: unicast entries come back unchanged
  p_ucast_kept_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tbl_wr_en_o && !tbl_rd_data_i[MCAST_BIT]) |-> (tbl_wr_data_o == tbl_rd_data_i));
  // R7: supervisory entries come back unchanged
  p_super_kept_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tbl_wr_en_o && tbl_rd_data_i[SUPER_BIT]) |-> (tbl_wr_data_o == tbl_rd_data_i));
  // R8: broadcast entries come back unchanged
  p_bcast_kept_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tbl_wr_en_o && (&tbl_rd_data_i[ADDR_W-1:0])) |-> (tbl_wr_data_o == tbl_rd_data_i));
  // R10: a rewritten port mask never gains a port
  p_mask_subset_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    tbl_wr_en_o |-> ((tbl_wr_data_o[PMASK_LSB +: NUM_PORTS] &
                      ~tbl_rd_data_i[PMASK_LSB +: NUM_PORTS]) == '0));
  // R11: freeing only happens when no port would remain
  p_free_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tbl_wr_en_o && tbl_wr_data_o[TYPE_LSB +: 2] == ENT_FREE) |->
      ((tbl_rd_data_i[PMASK_LSB +: NUM_PORTS] & ~fmask_q) == '0));
endmodule

// File: tb/mpf_flush_seq_bench.sv
module mpf_flush_seq_bench;
  localparam int NP    = 3;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = 66 + NP;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [NP-1:0] fmask;
  logic [11:0]   vid;
  logic          allv;
  logic          busy;
  logic          done;
  logic [AW-1:0] addr;
  logic          rd_en;
  logic [EW-1:0] rd_data;
  logic          wr_en;
  logic [EW-1:0] wr_data;

  logic          reload;
  int            seed;
  logic [EW-1:0] mem [DEPTH];
  int            wcnt [DEPTH];

  int compared;
  int mismatched;
  int cyc;

  mpf_flush_seq #(.NUM_PORTS(NP), .DEPTH(DEPTH)) u_mpf_flush_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .flush_mask_i  (fmask),
    .vid_i         (vid),
    .all_vlan_i    (allv),
    .busy_o        (busy),
    .done_o        (done),
    .tbl_addr_o    (addr),
    .tbl_rd_en_o   (rd_en),
    .tbl_rd_data_i (rd_data),
    .tbl_wr_en_o   (wr_en),
    .tbl_wr_data_o (wr_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [EW-1:0] gen(int i, int s);
    logic [EW-1:0] e;
    e = '0;
    e[61:60] = (i == 3) ? 2'd0 : (i == 7) ? 2'd2 : ((i % 4) >= 2) ? 2'd3 : 2'd1;
    e[59:48] = ((i % 8) >= 4) ? 12'd10 : 12'd20;
    if (i == 11)               e[47:0] = 48'hFFFF_FFFF_FFFF;
    else if (i == 1 || i == 9) e[47:0] = 48'h0200_0000_0000 + 48'(i);
    else                       e[47:0] = 48'h0100_5E00_0000 + 48'(i);
    e[63:62] = 2'(i % 4);
    e[64]    = 1'(i % 2);
    e[65]    = (i == 6);
    e[66 +: NP] = (i == 13) ? '0 : NP'((i * 3 + s) % 8);
    return e;
  endfunction

  // table model with one cycle of read latency
  always @(posedge clk) begin
    if (reload) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]  <= gen(i, seed);
        wcnt[i] <= 0;
      end
    end else begin
      if (rd_en) rd_data <= mem[addr];
      if (wr_en) begin
        mem[addr]  <= wr_data;
        wcnt[addr] <= wcnt[addr] + 1;
      end
    end
  end

  function automatic bit exp_written(logic [EW-1:0] e, logic [11:0] v, logic a);
    bit cls;
    cls = (e[61:60] == 2'd1) || (e[61:60] == 2'd3);
    return cls && (a || e[59:48] == v);
  endfunction

  function automatic logic [EW-1:0] exp_entry(logic [EW-1:0] e, logic [NP-1:0] m,
                                              logic [11:0] v, logic a);
    logic [EW-1:0] r;
    logic [NP-1:0] pm;
    r = e;
    if (!exp_written(e, v, a)) return r;
    if (!e[40] || e[65] || e[47:0] == 48'hFFFF_FFFF_FFFF) return r;
    pm = e[66 +: NP];
    if ((pm & m) == 0) return r;
    if ((pm & ~m) == 0) r[61:60] = 2'd0;
    else                r[66 +: NP] = pm & ~m;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic string req_for(logic [EW-1:0] e);
    if (!((e[61:60] == 2'd1) || (e[61:60] == 2'd3))) return "R4";
    if (!e[40]) return "R6";
    if (e[65]) return "R7";
    if (e[47:0] == 48'hFFFF_FFFF_FFFF) return "R8";
    return "R5/R9/R10/R11";
  endfunction

  task automatic run_one(int s, logic [NP-1:0] m, logic [11:0] v, logic a);
    int busy_n;
    bit seen_done;
    logic [EW-1:0] orig;
    logic [EW-1:0] expv;
    @(negedge clk);
    seed = s;
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    start = 1'b1;
    fmask = m;
    vid = v;
    allv = a;
    @(negedge clk);
    start = 1'b0;
    busy_n = 0;
    seen_done = 0;
    for (int n = 0; n < 2 * DEPTH + 6; n++) begin
      if (n == 4) begin
        // R2: second start during the scan with different parameters
        start = 1'b1;
        fmask = ~m;
        vid = v ^ 12'h01E;
        allv = ~a;
      end else if (n == 5) begin
        start = 1'b0;
      end
      if (done) begin
        seen_done = 1;
        check(busy == 1'b0, "R12 busy low with done", 128'(busy), 128'(0));
        break;
      end
      if (busy) busy_n++;
      @(negedge clk);
    end
    check(seen_done && busy_n == 2 * DEPTH, "R2 scan length",
          128'(busy_n), 128'(2 * DEPTH));
    @(negedge clk);
    check(done == 1'b0, "R12 done single pulse", 128'(done), 128'(0));
    for (int i = 0; i < DEPTH; i++) begin
      orig = gen(i, s);
      expv = exp_entry(orig, m, v, a);
      check(mem[i] == expv, req_for(orig), 128'(mem[i]), 128'(expv));
      // R3: one write per written index, none for skipped ones
      check(wcnt[i] == (exp_written(orig, v, a) ? 1 : 0), "R3/R4/R5 write count",
            128'(wcnt[i]), 128'(exp_written(orig, v, a)));
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    compared = 0;
    mismatched = 0;
    rst_n = 1'b0;
    start = 1'b0;
    fmask = '0;
    vid = '0;
    allv = 1'b0;
    reload = 1'b0;
    seed = 0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(!busy && !done && !rd_en && !wr_en, "R1 in reset",
          128'({busy, done, rd_en, wr_en}), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R1 after reset",
          128'({busy, done, rd_en, wr_en}), 128'(0));
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 8; m++)
        for (int a = 0; a < 2; a++)
          for (int vv = 0; vv < 2; vv++)
            run_one(s, NP'(m), (vv == 0) ? 12'd10 : 12'd20, 1'(a));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule